// File: doc/BRIEF.md
# Per-Edge Syndrome Decorrelator

This block sits on one edge of a syndrome-based non-binary check node, and one copy of it runs for each edge. Each cycle an upstream selector can hand it up to three groups of three syndromes. Two groups come from the single-deviation population and one from the double-deviation population. Each syndrome is a pair: a 6-bit field symbol and an 8-bit reliability value, where a smaller value means more reliable. Each group also carries a one-hot-per-edge mask that says which edges deviated from their most reliable input. All members of a group share that mask, so the block decides once per group whether the group may feed this edge. A group is rejected whenever this edge's own bit is set in the mask.

The block packs the surviving syndromes into six output lanes. Lane 0 is filled first and the arrival order is kept. Syndromes that do not fit are held back and leave first on the next cycle. Before a syndrome is written to a lane, the field symbol of this edge's most reliable input is removed from it by XOR. Reliability values pass through untouched.

A start pulse opens each check-node update. It latches the edge index, the reference symbol and the zero-deviation symbol, and the zero-deviation result leaves on a separate port. After exactly thirteen messages have been emitted for an update, the block emits nothing more until the next start.

Top module: `syndec_edge`

## Requirements
- R1: A group is dropped when it is marked absent, or when bit e of its mask is set, where e is the edge index latched at start and bit k of a mask means edge k deviated. Group g's mask occupies set_tag_i[g*NUM_EDGES +: NUM_EDGES]. A group with e's bit clear contributes all three of its syndromes.
- R2: Surviving syndromes fill lanes from lane 0 upward without gaps. Order is group 0 first, then group 1, then group 2, and within a group the order is member 0, then 1, then 2. Syndrome k of the input uses bits k*6 of syn_gf_i and k*8 of syn_llr_i.
- R3: Survivors that do not fit in this cycle's lanes are kept. On the following cycle they occupy the lowest lanes, ahead of any new arrivals, even when no new input arrives.
- R4: Each emitted lane carries gf equal to the input symbol XOR the reference symbol latched at start, and llr equal to the input value unchanged.
- R5: sent_cnt_o counts the messages emitted since start. Emission stops once the count reaches 13, and done_o is then high. Any further input yields no valid lane until the next start.
- R6: A start cycle clears the count and the held-back syndromes, and ignores the syndrome inputs of that cycle. It latches the edge index and the reference symbol, and d0_gf_o becomes the zero-deviation symbol XOR the reference symbol.
- R7: Lanes, count and done are registered. They reflect the inputs of the cycle before the clock edge.
- R8: Out of reset, no lane is valid, the count is 0, done is low and d0_gf_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new check-node update |
| edge_id_i | input | 2 | Index of this edge, latched at start |
| ref_gf_i | input | 6 | Most reliable field symbol of this edge, latched at start |
| d0_gf_i | input | 6 | Zero-deviation syndrome symbol, latched at start |
| in_vld_i | input | 1 | Syndrome groups are presented this cycle |
| set_present_i | input | 3 | Per-group presence flags |
| set_tag_i | input | 12 | Per-group deviating-edge masks |
| syn_gf_i | input | 54 | Nine syndrome field symbols |
| syn_llr_i | input | 72 | Nine syndrome reliability values |
| lane_vld_o | output | 6 | Lane valid flags |
| lane_gf_o | output | 36 | Corrected lane field symbols |
| lane_llr_o | output | 48 | Lane reliability values |
| d0_gf_o | output | 6 | Corrected zero-deviation symbol |
| sent_cnt_o | output | 4 | Messages emitted in the current update |
| done_o | output | 1 | Thirteen messages have been emitted |

## Verification
Directed cases cover four situations. A middle group blocked by this edge's own bit shows whether packing closes the gap correctly. An all-valid pair of cycles shows whether held-back syndromes really lead the next cycle. An idle cycle shows whether the carry drains without new input. Input after the limit shows whether the thirteen-message stop holds. Random updates draw random edge indices, masks, presence flags and payloads. These mix every number of surviving groups with partial carries and mid-cycle caps, and a bench model built from the requirements checks every lane, the count and the corrected symbols cycle by cycle.

// File: rtl/syndec_pkg.sv
package syndec_pkg;
  localparam int GF_W  = 6;
  localparam int LLR_W = 8;

  typedef struct packed {
    logic [GF_W-1:0]  gf;
    logic [LLR_W-1:0] llr;
  } syn_t;
endpackage

// File: rtl/syndec_setgate.sv
module syndec_setgate #(
  parameter int NUM_EDGES = 4,
  localparam int EW = (NUM_EDGES > 1) ? $clog2(NUM_EDGES) : 1
) (
  input  logic [NUM_EDGES-1:0] tag_i,
  input  logic [EW-1:0]        edge_i,
  input  logic                 present_i,
  input  logic                 arrive_i,
  output logic                 ok_o
);
  // a group feeds this edge only if this edge did not deviate in it
  always_comb begin
    ok_o = arrive_i & present_i & ~tag_i[edge_i];
  end
endmodule

// File: rtl/syndec_compact.sv
module syndec_compact
  import syndec_pkg::*;
#(
  parameter int P     = 16,
  parameter int OUT_N = 6,
  parameter int CAR_N = 7,
  localparam int CW   = $clog2(P + 1)
) (
  input  syn_t           ent_i [P],
  input  logic [P-1:0]   ok_i,
  input  logic [CW-1:0]  base_i,
  output syn_t           lane_o [OUT_N],
  output syn_t           car_o [CAR_N]
);
  logic [CW-1:0] rank;

  // rank of each surviving entry picks its lane or its carry slot
  always_comb begin
    rank   = '0;
    lane_o = '{default: '0};
    car_o  = '{default: '0};
    for (int i = 0; i < P; i++) begin
      if (ok_i[i]) begin
        for (int j = 0; j < OUT_N; j++) begin
          if (rank == CW'(j)) lane_o[j] = ent_i[i];
        end
        for (int k = 0; k < CAR_N; k++) begin
          if (rank == CW'(base_i + CW'(k))) car_o[k] = ent_i[i];
        end
        rank = rank + 1'b1;
      end
    end
  end
endmodule

// File: rtl/syndec_budget.sv
module syndec_budget #(
  parameter int MSG_TOTAL = 13,
  parameter int OUT_LANES = 6,
  parameter int CAR_N     = 7,
  parameter int CW        = 5,
  localparam int CNT_W    = $clog2(MSG_TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [CW-1:0]    pend_i,
  output logic [CW-1:0]    take_o,
  output logic [CW-1:0]    keep_o,
  output logic [CNT_W-1:0] sent_o,
  output logic             done_o
);
  logic [CNT_W-1:0] sent_q, sent_n;
  int need, t, k;

  always_comb begin
    need = MSG_TOTAL - int'(sent_q);
    t    = int'(pend_i);
    if (t > OUT_LANES) t = OUT_LANES;
    if (t > need) t = need;
    k = int'(pend_i) - t;
    if (k > need - t) k = need - t;
    if (k > CAR_N) k = CAR_N;
    if (clr_i) begin
      t = 0;
      k = 0;
    end
    take_o = CW'(t);
    keep_o = CW'(k);
    sent_n = clr_i ? '0 : CNT_W'(int'(sent_q) + t);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sent_q <= '0;
    else        sent_q <= sent_n;
  end

  assign sent_o = sent_q;
  assign done_o = (sent_q == CNT_W'(MSG_TOTAL));

  a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sent_q) <= MSG_TOTAL);
  a_r5_no_take_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> take_o == '0);
endmodule

// File: rtl/syndec_edge.sv
module syndec_edge
  import syndec_pkg::*;
#(
  parameter int NUM_EDGES = 4,
  parameter int SET_SZ    = 3,
  parameter int NUM_SETS  = 3,
  parameter int OUT_LANES = 6,
  parameter int MSG_TOTAL = 13
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start_i,
  input  logic [$clog2(NUM_EDGES)-1:0]           edge_id_i,
  input  logic [GF_W-1:0]                        ref_gf_i,
  input  logic [GF_W-1:0]                        d0_gf_i,
  input  logic                                   in_vld_i,
  input  logic [NUM_SETS-1:0]                    set_present_i,
  input  logic [NUM_SETS*NUM_EDGES-1:0]          set_tag_i,
  input  logic [NUM_SETS*SET_SZ*GF_W-1:0]        syn_gf_i,
  input  logic [NUM_SETS*SET_SZ*LLR_W-1:0]       syn_llr_i,
  output logic [OUT_LANES-1:0]                   lane_vld_o,
  output logic [OUT_LANES*GF_W-1:0]              lane_gf_o,
  output logic [OUT_LANES*LLR_W-1:0]             lane_llr_o,
  output logic [GF_W-1:0]                        d0_gf_o,
  output logic [$clog2(MSG_TOTAL+1)-1:0]         sent_cnt_o,
  output logic                                   done_o
);
  localparam int NSYN  = NUM_SETS * SET_SZ;
  localparam int CAR_N = MSG_TOTAL - OUT_LANES;
  localparam int P     = CAR_N + NSYN;
  localparam int CW    = $clog2(P + 1);
  localparam int EW    = $clog2(NUM_EDGES);
  localparam int CNT_W = $clog2(MSG_TOTAL + 1);

  logic [EW-1:0]        edge_q, edge_n;
  logic [GF_W-1:0]      ref_q, ref_n, d0_q, d0_n;
  syn_t                 car_q [CAR_N];
  syn_t                 car_n [CAR_N];
  logic [CW-1:0]        car_cnt_q, car_cnt_n;
  syn_t                 lane_q [OUT_LANES];
  syn_t                 lane_n [OUT_LANES];
  logic [OUT_LANES-1:0] lane_vld_q, lane_vld_n;

  logic [NUM_SETS-1:0]  set_ok;
  syn_t                 ent [P];
  logic [P-1:0]         ent_ok;
  syn_t                 sel_lane [OUT_LANES];
  syn_t                 sel_car [CAR_N];
  logic [CW-1:0]        pend, take, keep;
  logic                 arrive;

  assign arrive = in_vld_i & ~start_i;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_gate
    syndec_setgate #(.NUM_EDGES(NUM_EDGES)) u_gate (
      .tag_i     (set_tag_i[s*NUM_EDGES +: NUM_EDGES]),
      .edge_i    (edge_q),
      .present_i (set_present_i[s]),
      .arrive_i  (arrive),
      .ok_o      (set_ok[s])
    );
  end

  // carried entries sit ahead of new arrivals
  for (genvar c = 0; c < CAR_N; c++) begin : g_carry_ent
    assign ent[c]    = car_q[c];
    assign ent_ok[c] = (car_cnt_q > CW'(c));
  end

  for (genvar m = 0; m < NSYN; m++) begin : g_new_ent
    assign ent[CAR_N+m].gf  = syn_gf_i[m*GF_W +: GF_W];
    assign ent[CAR_N+m].llr = syn_llr_i[m*LLR_W +: LLR_W];
    assign ent_ok[CAR_N+m]  = set_ok[m / SET_SZ];
  end

  assign pend = CW'($countones(ent_ok));

  syndec_budget #(
    .MSG_TOTAL (MSG_TOTAL),
    .OUT_LANES (OUT_LANES),
    .CAR_N     (CAR_N),
    .CW        (CW)
  ) u_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .pend_i (pend),
    .take_o (take),
    .keep_o (keep),
    .sent_o (sent_cnt_o),
    .done_o (done_o)
  );

  syndec_compact #(
    .P     (P),
    .OUT_N (OUT_LANES),
    .CAR_N (CAR_N)
  ) u_compact (
    .ent_i  (ent),
    .ok_i   (ent_ok),
    .base_i (take),
    .lane_o (sel_lane),
    .car_o  (sel_car)
  );

  always_comb begin
    edge_n = edge_q;
    ref_n  = ref_q;
    d0_n   = d0_q;
    if (start_i) begin
      edge_n = edge_id_i;
      ref_n  = ref_gf_i;
      d0_n   = d0_gf_i ^ ref_gf_i;
    end
    for (int j = 0; j < OUT_LANES; j++) begin
      lane_vld_n[j] = (CW'(j) < take);
      lane_n[j]     = '0;
      if (lane_vld_n[j]) begin
        lane_n[j].gf  = sel_lane[j].gf ^ ref_q;
        lane_n[j].llr = sel_lane[j].llr;
      end
    end
    car_n     = sel_car;
    car_cnt_n = keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q     <= '0;
      ref_q      <= '0;
      d0_q       <= '0;
      car_q      <= '{default: '0};
      car_cnt_q  <= '0;
      lane_q     <= '{default: '0};
      lane_vld_q <= '0;
    end else begin
      edge_q     <= edge_n;
      ref_q      <= ref_n;
      d0_q       <= d0_n;
      car_q      <= car_n;
      car_cnt_q  <= car_cnt_n;
      lane_q     <= lane_n;
      lane_vld_q <= lane_vld_n;
    end
  end

  for (genvar j = 0; j < OUT_LANES; j++) begin : g_out
    assign lane_gf_o[j*GF_W +: GF_W]    = lane_q[j].gf;
    assign lane_llr_o[j*LLR_W +: LLR_W] = lane_q[j].llr;
  end
  assign lane_vld_o = lane_vld_q;
  assign d0_gf_o    = d0_q;

  // R3: held-back syndromes always lead the next cycle
  a_r3_carry_first: assert property (@(posedge clk) disable iff (!rst_n)
    (car_cnt_q != '0 && !start_i) |=> lane_vld_o[0]);
  // R2: valid lanes form a contiguous run from lane 0
  a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_vld_o + 1'b1) & lane_vld_o) == '0);
  // R6: a start cycle emits nothing and zeroes the count
  a_r6_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (lane_vld_o == '0 && sent_cnt_o == '0));
  // R5: count advances by exactly the lanes emitted
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> sent_cnt_o == CNT_W'($past(sent_cnt_o) + CNT_W'($countones(lane_vld_o))));
  // R5: nothing leaves after the limit
  a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> lane_vld_o == '0);
endmodule

// File: tb/syndec_edge_tb.sv
`timescale 1ns/1ps
module syndec_edge_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  edge_id_i;
  logic [5:0]  ref_gf_i, d0_gf_i;
  logic        in_vld_i;
  logic [2:0]  set_present_i;
  logic [11:0] set_tag_i;
  logic [53:0] syn_gf_i;
  logic [71:0] syn_llr_i;
  logic [5:0]  lane_vld_o;
  logic [35:0] lane_gf_o;
  logic [47:0] lane_llr_o;
  logic [5:0]  d0_gf_o;
  logic [3:0]  sent_cnt_o;
  logic        done_o;

  always #2 clk = ~clk;

  syndec_edge u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .edge_id_i(edge_id_i),
    .ref_gf_i(ref_gf_i), .d0_gf_i(d0_gf_i), .in_vld_i(in_vld_i),
    .set_present_i(set_present_i), .set_tag_i(set_tag_i),
    .syn_gf_i(syn_gf_i), .syn_llr_i(syn_llr_i), .lane_vld_o(lane_vld_o),
    .lane_gf_o(lane_gf_o), .lane_llr_o(lane_llr_o), .d0_gf_o(d0_gf_o),
    .sent_cnt_o(sent_cnt_o), .done_o(done_o)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  // bench model state
  logic [13:0] mq [32];
  int          mqn = 0, m_sent = 0;
  logic [1:0]  m_edge = 0;
  logic [5:0]  m_ref = 0, m_d0 = 0;
  logic [13:0] exp_lane [6];
  logic [5:0]  exp_vld;

  always @(posedge clk) cyc++;

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // model from the requirements, evaluated on the inputs of this cycle
  task automatic model_step();
    int need, n, keep;
    exp_vld = '0;
    for (int j = 0; j < 6; j++) exp_lane[j] = '0;
    if (start_i) begin
      mqn = 0; m_sent = 0; m_edge = edge_id_i; m_ref = ref_gf_i;
      m_d0 = d0_gf_i ^ ref_gf_i;
      return;
    end
    if (in_vld_i) begin
      for (int s = 0; s < 3; s++) begin
        if (set_present_i[s] && !set_tag_i[s*4 + m_edge]) begin
          for (int m = 0; m < 3; m++) begin
            mq[mqn] = {syn_gf_i[(s*3+m)*6 +: 6], syn_llr_i[(s*3+m)*8 +: 8]};
            mqn++;
          end
        end
      end
    end
    need = 13 - m_sent;
    n = min2(min2(mqn, 6), need);
    for (int j = 0; j < n; j++) begin
      exp_vld[j]  = 1'b1;
      exp_lane[j] = {mq[j][13:8] ^ m_ref, mq[j][7:0]};
    end
    for (int j = 0; j < mqn - n; j++) mq[j] = mq[j+n];
    keep = min2(mqn - n, need - n);
    mqn = keep;
    m_sent += n;
  endtask

  task automatic compare(string tag);
    check(tag, "lane_vld", int'(lane_vld_o), int'(exp_vld));
    for (int j = 0; j < 6; j++) begin
      if (exp_vld[j]) begin
        check(tag, "lane_gf",  int'(lane_gf_o[j*6 +: 6]),  int'(exp_lane[j][13:8]));
        check(tag, "lane_llr", int'(lane_llr_o[j*8 +: 8]), int'(exp_lane[j][7:0]));
      end
    end
    check(tag, "sent_cnt", int'(sent_cnt_o), m_sent);
    check(tag, "done", int'(done_o), int'(m_sent == 13));
    check(tag, "d0_gf", int'(d0_gf_o), int'(m_d0));
  endtask

  task automatic fill_random_payload();
    for (int k = 0; k < 9; k++) begin
      syn_gf_i[k*6 +: 6]  = 6'($urandom);
      syn_llr_i[k*8 +: 8] = 8'($urandom);
    end
  endtask

  // drive at negedge, check one cycle later at negedge (R7)
  task automatic step(string tag, bit st, bit iv, logic [2:0] pres, logic [11:0] tags);
    start_i = st; in_vld_i = iv; set_present_i = pres; set_tag_i = tags;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic begin_update(string tag, logic [1:0] e, logic [5:0] r, logic [5:0] d0);
    edge_id_i = e; ref_gf_i = r; d0_gf_i = d0;
    fill_random_payload();
    step(tag, 1'b1, 1'b1, 3'b111, 12'h000);
  endtask

  initial begin
    #300000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_i = 0; edge_id_i = 0; ref_gf_i = 0; d0_gf_i = 0;
    in_vld_i = 0; set_present_i = 0; set_tag_i = 0; syn_gf_i = 0; syn_llr_i = 0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "lane_vld", int'(lane_vld_o), 0);
    check("R8", "sent_cnt", int'(sent_cnt_o), 0);
    check("R8", "done", int'(done_o), 0);
    check("R8", "d0_gf", int'(d0_gf_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: start latches reference, ignores input in the same cycle
    begin_update("R6", 2'd2, 6'h2A, 6'h11);
    check("R6", "d0_corrected", int'(d0_gf_o), int'(6'h3B));
    // R1: middle group names edge 2 and must vanish; R2 packing closes the gap
    fill_random_payload();
    step("R1", 1'b0, 1'b1, 3'b111, {4'b0000, 4'b0100, 4'b0001});
    // R4: corrected field symbol of first lane from group 0 member 0
    check("R4", "gf_xor", int'(lane_gf_o[5:0]), int'(syn_gf_i[5:0] ^ 6'h2A));
    check("R4", "llr_pass", int'(lane_llr_o[7:0]), int'(syn_llr_i[7:0]));
    // R1: absent group ignored
    fill_random_payload();
    step("R1", 1'b0, 1'b1, 3'b010, 12'h000);

    // R3: nine survivors, six out, three carried ahead of new ones
    begin_update("R6", 2'd0, 6'h15, 6'h00);
    fill_random_payload();
    step("R3", 1'b0, 1'b1, 3'b111, 12'hEEE);
    fill_random_payload();
    step("R3", 1'b0, 1'b1, 3'b111, 12'h000);
    // R3: carried remainder drains with no input; R5: reaches 13
    step("R3", 1'b0, 1'b0, 3'b000, 12'h000);
    check("R5", "done_at_13", int'(done_o), 1);
    // R5: no more output after the limit
    fill_random_payload();
    step("R5", 1'b0, 1'b1, 3'b111, 12'h000);
    check("R5", "quiet_after_done", int'(lane_vld_o), 0);

    // R2: random updates
    for (int u = 0; u < 300; u++) begin
      begin_update("R6", 2'($urandom), 6'($urandom), 6'($urandom));
      for (int c = 0; c < 8; c++) begin
        fill_random_payload();
        step("R2", 1'b0, 1'($urandom % 4 != 0), 3'($urandom), 12'($urandom));
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule